// File: doc/BRIEF.md
# Per-Area Read Strobe Timing Generator

This block drives the active-low read strobe of an external bus for one read cycle at a time. Eight address areas are supported. Each area has one timing bit in a 16-bit control register. The bit chooses whether the strobe is released at the very end of the read cycle or half a bus cycle before it. The read-data capture pulse moves with the release point, so the bus master always latches data on the last tick in which the strobe is still driven low.

The block runs on a phase clock at twice the bus clock rate, so one phase tick is half a bus clock. A one-tick start request carries three values: the target area, the area's interface type and the cycle length N in bus clocks. The cycle then takes 2N ticks. Two interface types ignore the register bit and force a fixed release point. The other two follow the register bit. While a cycle runs, the busy output is high and further start requests are dropped.

Top module: `rd_strobe_timer`

## Requirements
- R1: Control register bit 8+n is the timing bit for area n (n = 0..7). A write sets bits 15..8 from the written data, and a read returns them unchanged.
- R2: Register bits 7..0 always read as zero, and writing ones to them has no effect.
- R3: After reset the register reads 0, the strobe output is high, the capture output is low and busy is low.
- R4: A start is accepted on a clock edge where busy is low. The strobe is low from the tick after that edge. With the timing bit at 0 on interface type 0 (basic) or 3 (address/data multiplexed), the strobe is released when tick 2N is reached, so it stays low for 2N-1 ticks.
- R5: With the timing bit at 1 on interface type 0 or 3, the strobe is released at tick 2N-1, so it stays low for 2N-2 ticks.
- R6: On interface type 1 (byte-control SRAM), the strobe always uses the early release of R5, whatever the register bit.
- R7: On interface type 2 (burst ROM), the strobe always uses the end-of-cycle release of R4, whatever the register bit.
- R8: The capture output pulses high for exactly one tick per cycle. That tick is the last tick in which the strobe is low.
- R9: Busy is high for exactly 2N ticks, starting from the tick after an accepted start. A start request while busy is high is dropped: it neither restarts nor extends the cycle, and it is not queued.
- R10: A cycle length input below 2 is treated as 2.
- R11: The area's timing bit is taken from the register as it stood before the accepting edge. A register write on that same edge, or later during the cycle, only affects later cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Phase clock, twice the bus clock rate |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Control register write enable |
| regWrData | input | 16 | Control register write data |
| regRdData | output | 16 | Control register read data |
| cycStart | input | 1 | One-tick read cycle start request |
| cycArea | input | 3 | Target area of the requested cycle |
| cycIfType | input | 2 | Interface type: 0 basic, 1 byte-control SRAM, 2 burst ROM, 3 multiplexed |
| cycLen | input | 4 | Cycle length N in bus clocks (2..15) |
| rdStrobeN | output | 1 | Active-low read strobe |
| capturePulse | output | 1 | One-tick read data capture pulse |
| busy | output | 1 | High while a read cycle is in progress |

## Verification
Two things can land on the same clock edge: a control register write and the acceptance of a start. A new start request can also arrive while a cycle is still counting. The bench drives a register write together with the start pulse, and again in the middle of a cycle. It then checks that the measured strobe width matches the old timing bit. It also raises a second start with a different area partway through a cycle and confirms that busy lasts exactly 2N ticks and then stays low. The cycle widths from a vector table cover every interface type, both values of the timing bit, and the lowest, middle and highest cycle lengths.

// File: rtl/rd_strobe_pkg.sv
package rd_strobe_pkg;

  typedef enum logic [1:0] {
    IF_BASIC = 2'd0,
    IF_BYTE_SRAM = 2'd1,
    IF_BURST_ROM = 2'd2,
    IF_MUXED = 2'd3
  } ifType_e;

  typedef struct packed {
    logic active;
    logic load;
    logic step;
    logic clear;
  } seqCtl_t;

  function automatic logic resolveEarly(input logic [1:0] ifType, input logic areaBit);
    case (ifType)
      IF_BYTE_SRAM: resolveEarly = 1'b1;
      IF_BURST_ROM: resolveEarly = 1'b0;
      default: resolveEarly = areaBit;
    endcase
  endfunction

endpackage

// File: rtl/rd_strobe_regs.sv
module rd_strobe_regs #(
  parameter int REG_W = 16,
  parameter int NUM_AREAS = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic wrEn,
  input  logic [REG_W-1:0] wrData,
  output logic [REG_W-1:0] rdData,
  output logic [NUM_AREAS-1:0] timingBits
);
  localparam int FIELD_LSB = REG_W - NUM_AREAS;

  logic [NUM_AREAS-1:0] timingQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) timingQ <= '0;
    else if (wrEn) timingQ <= wrData[FIELD_LSB +: NUM_AREAS];
  end

  always_comb begin
    rdData = '0;
    rdData[FIELD_LSB +: NUM_AREAS] = timingQ;
  end

  assign timingBits = timingQ;

  AST_WRITE_TAKES: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> rdData[FIELD_LSB +: NUM_AREAS] == $past(wrData[FIELD_LSB +: NUM_AREAS])); // R1

endmodule

// File: rtl/rd_strobe_ctrl.sv
module rd_strobe_ctrl
  import rd_strobe_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic startReq,
  input  logic atEnd,
  output seqCtl_t ctl,
  output logic busy
);
  logic busyQ;

  always_comb begin
    ctl.active = busyQ;
    ctl.load = startReq && !busyQ;
    ctl.step = busyQ && !atEnd;
    ctl.clear = busyQ && atEnd;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busyQ <= 1'b0;
    else if (ctl.load) busyQ <= 1'b1;
    else if (ctl.clear) busyQ <= 1'b0;
  end

  assign busy = busyQ;

  AST_HOLD_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && !atEnd) |=> busyQ); // R9
  AST_BUSY_END: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && atEnd) |=> !busyQ); // R9

endmodule

// File: rtl/rd_strobe_datapath.sv
module rd_strobe_datapath
  import rd_strobe_pkg::*;
#(
  parameter int LEN_W = 4,
  parameter int MIN_LEN = 2
) (
  input  logic clk,
  input  logic rstN,
  input  seqCtl_t ctl,
  input  logic [LEN_W-1:0] lenIn,
  input  logic earlyIn,
  input  logic [1:0] ifTypeIn,
  output logic atEnd,
  output logic rdStrobeN,
  output logic capturePulse
);
  localparam int CNT_W = LEN_W + 1;
  localparam logic [CNT_W-1:0] MIN_TICKS = CNT_W'(2 * MIN_LEN);

  logic [CNT_W-1:0] tickQ;
  logic [CNT_W-1:0] endTickQ;
  logic [CNT_W-1:0] negTickQ;
  logic [CNT_W-1:0] endTickD;
  logic strobeLow;

  always_comb begin
    endTickD = {lenIn, 1'b0};
    if (endTickD < MIN_TICKS) endTickD = MIN_TICKS;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tickQ <= '0;
      endTickQ <= MIN_TICKS;
      negTickQ <= MIN_TICKS;
    end else if (ctl.load) begin
      tickQ <= CNT_W'(1);
      endTickQ <= endTickD;
      negTickQ <= earlyIn ? endTickD - CNT_W'(1) : endTickD;
    end else if (ctl.step) begin
      tickQ <= tickQ + CNT_W'(1);
    end else if (ctl.clear) begin
      tickQ <= '0;
    end
  end

  assign atEnd = (tickQ == endTickQ);
  assign strobeLow = ctl.active && (tickQ < negTickQ);
  assign rdStrobeN = !strobeLow;
  assign capturePulse = ctl.active && (tickQ == negTickQ - CNT_W'(1));

  AST_TICK_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.active && !atEnd) |=> tickQ == $past(tickQ) + CNT_W'(1)); // R4
  AST_SRAM_EARLY: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.load && ifTypeIn == IF_BYTE_SRAM) |=> negTickQ == endTickQ - CNT_W'(1)); // R6
  AST_BURST_NORMAL: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.load && ifTypeIn == IF_BURST_ROM) |=> negTickQ == endTickQ); // R7
  AST_CAPTURE_THEN_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    capturePulse |=> rdStrobeN); // R8
  AST_MIN_LEN: assert property (@(posedge clk) disable iff (!rstN)
    ctl.load |=> endTickQ >= MIN_TICKS); // R10

endmodule

// File: rtl/rd_strobe_timer.sv
module rd_strobe_timer
  import rd_strobe_pkg::*;
#(
  parameter int REG_W = 16,
  parameter int NUM_AREAS = 8,
  parameter int LEN_W = 4,
  localparam int AREA_W = $clog2(NUM_AREAS)
) (
  input  logic clk,
  input  logic rstN,
  input  logic regWrEn,
  input  logic [REG_W-1:0] regWrData,
  output logic [REG_W-1:0] regRdData,
  input  logic cycStart,
  input  logic [AREA_W-1:0] cycArea,
  input  logic [1:0] cycIfType,
  input  logic [LEN_W-1:0] cycLen,
  output logic rdStrobeN,
  output logic capturePulse,
  output logic busy
);
  logic [NUM_AREAS-1:0] timingBits;
  logic earlyReq;
  logic atEnd;
  seqCtl_t ctl;

  rd_strobe_regs #(.REG_W(REG_W), .NUM_AREAS(NUM_AREAS)) u_regs (
    .clk(clk), .rstN(rstN), .wrEn(regWrEn), .wrData(regWrData),
    .rdData(regRdData), .timingBits(timingBits)
  );

  assign earlyReq = resolveEarly(cycIfType, timingBits[cycArea]);

  rd_strobe_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .startReq(cycStart), .atEnd(atEnd),
    .ctl(ctl), .busy(busy)
  );

  rd_strobe_datapath #(.LEN_W(LEN_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .lenIn(cycLen), .earlyIn(earlyReq),
    .ifTypeIn(cycIfType), .atEnd(atEnd), .rdStrobeN(rdStrobeN),
    .capturePulse(capturePulse)
  );

endmodule

// File: tb/rd_strobe_timer_tb.sv
`timescale 1ns/1ps
module rd_strobe_timer_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic [15:0] regWrData = '0;
  logic [15:0] regRdData;
  logic cycStart = 1'b0;
  logic [2:0] cycArea = '0;
  logic [1:0] cycIfType = '0;
  logic [3:0] cycLen = 4'd2;
  logic rdStrobeN;
  logic capturePulse;
  logic busy;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  rd_strobe_timer u_dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .cycStart(cycStart), .cycArea(cycArea),
    .cycIfType(cycIfType), .cycLen(cycLen), .rdStrobeN(rdStrobeN),
    .capturePulse(capturePulse), .busy(busy)
  );

  typedef struct packed {
    logic [2:0] area;
    logic [1:0] ifType;
    logic [3:0] len;
    logic [7:0] field;
    logic early;
  } vec_t;

  localparam int NVEC = 10;
  localparam vec_t VECS [NVEC] = '{
    '{3'd0, 2'd0, 4'd2, 8'h00, 1'b0},  // R4
    '{3'd0, 2'd0, 4'd2, 8'h01, 1'b1},  // R5
    '{3'd3, 2'd3, 4'd5, 8'h08, 1'b1},  // R5
    '{3'd3, 2'd3, 4'd5, 8'hF7, 1'b0},  // R4
    '{3'd7, 2'd1, 4'd4, 8'h00, 1'b1},  // R6
    '{3'd6, 2'd2, 4'd6, 8'hFF, 1'b0},  // R7
    '{3'd5, 2'd0, 4'd15, 8'h20, 1'b1}, // R5
    '{3'd1, 2'd1, 4'd3, 8'hFF, 1'b1},  // R6
    '{3'd2, 2'd2, 4'd7, 8'h00, 1'b0},  // R7
    '{3'd4, 2'd0, 4'd9, 8'hEF, 1'b0}   // R4
  };

  task automatic check(input string req, input string what, input int act, input int exp);
    testsRun++;
    if (act != exp) begin
      testsFailed++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic regWrite(input logic [15:0] val);
    @(negedge clk);
    regWrEn = 1'b1;
    regWrData = val;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic runCycle(input logic [2:0] a, input logic [1:0] t, input logic [3:0] n,
                          input bit sameWr, input bit midWr, input bit midStart,
                          input logic [15:0] wrVal,
                          output int lowT, output int capT, output int capN,
                          output int busyT, output int firstLow);
    lowT = 0; capT = 0; capN = 0; busyT = 0; firstLow = 0;
    @(negedge clk);
    cycArea = a; cycIfType = t; cycLen = n; cycStart = 1'b1;
    if (sameWr) begin regWrEn = 1'b1; regWrData = wrVal; end
    @(negedge clk);
    cycStart = 1'b0;
    regWrEn = 1'b0;
    for (int k = 1; k <= 40; k++) begin
      if (!rdStrobeN) begin
        lowT++;
        if (firstLow == 0) firstLow = k;
      end
      if (capturePulse) begin capN++; capT = k; end
      if (busy) busyT++;
      regWrEn = 1'b0;
      cycStart = 1'b0;
      if (midWr && k == 2) begin regWrEn = 1'b1; regWrData = wrVal; end
      if (midStart && k == 3) begin cycStart = 1'b1; cycArea = a + 3'd1; cycLen = 4'd15; end
      @(negedge clk);
    end
    regWrEn = 1'b0;
    cycStart = 1'b0;
  endtask

  task automatic expectCycle(input string req, input int n, input bit early,
                             input int lowT, input int capT, input int capN,
                             input int busyT, input int firstLow);
    int nn;
    int neg;
    nn = (n < 2) ? 2 : n;
    neg = 2 * nn - (early ? 1 : 0);
    check(req, "strobe low ticks", lowT, neg - 1);
    check(req, "first low tick", firstLow, 1);
    check("R8", "capture tick", capT, neg - 1);
    check("R8", "capture count", capN, 1);
    check("R9", "busy ticks", busyT, 2 * nn);
  endtask

  initial begin
    #800000;
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    int lowT, capT, capN, busyT, firstLow;
    repeat (3) @(negedge clk);
    // R3: reset state
    check("R3", "reg after reset", int'(regRdData), 0);
    check("R3", "strobe after reset", int'(rdStrobeN), 1);
    check("R3", "capture after reset", int'(capturePulse), 0);
    check("R3", "busy after reset", int'(busy), 0);
    rstN = 1'b1;
    @(negedge clk);

    // R1 and R2: field readback, reserved bits read zero
    regWrite(16'hA5FF);
    check("R1", "timing field readback", int'(regRdData[15:8]), 'hA5);
    check("R2", "reserved bits", int'(regRdData[7:0]), 0);
    regWrite(16'h3C00);
    check("R1", "timing field readback 2", int'(regRdData), 'h3C00);

    // table walk over areas, interface types, lengths
    for (int i = 0; i < NVEC; i++) begin
      regWrite({VECS[i].field, 8'hFF});
      runCycle(VECS[i].area, VECS[i].ifType, VECS[i].len, 1'b0, 1'b0, 1'b0, 16'h0,
               lowT, capT, capN, busyT, firstLow);
      expectCycle(VECS[i].early ? "R5/R6" : "R4/R7", int'(VECS[i].len), VECS[i].early,
                  lowT, capT, capN, busyT, firstLow);
    end

    // R10: length below minimum
    regWrite(16'h0000);
    runCycle(3'd2, 2'd0, 4'd0, 1'b0, 1'b0, 1'b0, 16'h0, lowT, capT, capN, busyT, firstLow);
    expectCycle("R10", 0, 1'b0, lowT, capT, capN, busyT, firstLow);
    regWrite(16'h0400);
    runCycle(3'd2, 2'd3, 4'd1, 1'b0, 1'b0, 1'b0, 16'h0, lowT, capT, capN, busyT, firstLow);
    expectCycle("R10", 1, 1'b1, lowT, capT, capN, busyT, firstLow);

    // R9: start while busy is dropped
    regWrite(16'h0000);
    runCycle(3'd1, 2'd0, 4'd4, 1'b0, 1'b0, 1'b1, 16'h0, lowT, capT, capN, busyT, firstLow);
    expectCycle("R9", 4, 1'b0, lowT, capT, capN, busyT, firstLow);
    check("R9", "busy after dropped start", int'(busy), 0);

    // R11: write on the accepting edge uses the old bit
    regWrite(16'h0000);
    runCycle(3'd6, 2'd0, 4'd5, 1'b1, 1'b0, 1'b0, 16'hFF00, lowT, capT, capN, busyT, firstLow);
    expectCycle("R11", 5, 1'b0, lowT, capT, capN, busyT, firstLow);
    check("R11", "same-edge write landed", int'(regRdData), 'hFF00);
    // R11: write during the cycle does not change it
    runCycle(3'd6, 2'd3, 4'd5, 1'b0, 1'b1, 1'b0, 16'h0000, lowT, capT, capN, busyT, firstLow);
    expectCycle("R11", 5, 1'b1, lowT, capT, capN, busyT, firstLow);
    // next cycle sees the new (cleared) bit
    runCycle(3'd6, 2'd3, 4'd5, 1'b0, 1'b0, 1'b0, 16'h0, lowT, capT, capN, busyT, firstLow);
    expectCycle("R11", 5, 1'b0, lowT, capT, capN, busyT, firstLow);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule